// File: doc/BRIEF.md
# Protected Register Bank Unlock Sequencer

This block sits behind a serial-bus slave front end. The front end decodes the bus bits. This block receives one event per transfer: start, stop, a completed byte, or an abort when the framing goes wrong. From those events it tracks the write transactions aimed at its device address and keeps two enable latches. One is a write-enable latch. The other is a bank-write latch, which is set by a second and more specific status command. The latches together guard a bank of eight persistent control registers.

A burst of data bytes for the bank is collected in a staging buffer while the transaction runs. The burst is accepted only if it ends with a clean stop while both latches are set. It then starts a commit that stays busy for a parameterised number of cycles, which stands in for the slow persistent write. When the commit finishes, the staged bytes are copied into the bank and the bank-write latch drops. Software must therefore repeat the unlock for every change. Read transactions, transactions to other device addresses, and any write that arrives while the block is busy leave the latches and the bank untouched.

The device address for writes is DEh; the same value with bit 0 set (DFh) is a read. The status register sits at address 3Fh. The bank occupies addresses 10h to 17h. One address byte follows the device address, and the address pointer advances after every data byte.

Top module: `unlock_seq`

## Requirements
- R1: After reset, `wel`, `rwel` and `busy` are 0 and every bank register reads 00h on `regFile`, where register i occupies bits [8i+7:8i].
- R2: A write transaction made of a start, device byte DEh, address byte 3Fh, data byte 02h and a stop sets `wel` in the cycle after the stop. It does not raise `busy`.
- R3: Data 06h written to 3Fh sets `rwel` (and keeps `wel`) only when `wel` is already 1. When `wel` is 0 it changes nothing. Any value other than 00h, 02h or 06h leaves both latches unchanged, and `rwel` is never 1 while `wel` is 0.
- R4: Data 00h written to 3Fh clears both `wel` and `rwel`.
- R5: A transaction of start, DEh, an address byte and one or more data bytes, ended by a stop, starts a commit if `wel` and `rwel` are both 1 and at least one byte hit the bank. `busy` rises the cycle after the stop and stays high for exactly COMMIT_CYCLES cycles. Then each staged byte appears in its register, and the pointer has advanced by one per data byte.
- R6: When a commit finishes, `rwel` returns to 0 and `wel` stays 1. A further bank write without a new 06h unlock changes nothing.
- R7: A bank write ended by a stop while `rwel` is 0 starts no commit and leaves the bank unchanged.
- R8: A write that ends with `abortEv`, or with a start before its stop, starts no commit and leaves `rwel` and `wel` as they were.
- R9: Transactions whose device byte is not DEh (including the read byte DFh) change neither the latches nor the bank.
- R10: Data bytes whose pointer address lies outside 10h–17h and is not 3Fh are dropped. The pointer still advances past them, so a burst can run from below 10h into the bank, or from inside the bank past 17h.
- R11: While `busy` is 1, write transactions, including status writes, are ignored. The bank changes only in the cycle the commit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEv | input | 1 | One-cycle pulse: start or repeated start seen |
| stopEv | input | 1 | One-cycle pulse: stop seen |
| abortEv | input | 1 | One-cycle pulse: transfer ended with bad framing |
| byteEv | input | 1 | One-cycle pulse: a complete byte is on `byteVal` |
| byteVal | input | 8 | Byte received from the bus master |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Bank-write enable latch |
| busy | output | 1 | Persistent commit in progress |
| regFile | output | 64 | Bank contents, register i in bits [8i+7:8i] |

## Verification
The bench builds the block with COMMIT_CYCLES set to 40 instead of a full persistent-write time. At that length the exact busy window can be counted cycle by cycle. The short window also leaves room to send whole write and status transactions while the commit is still running, which checks that they are ignored. All other parameters keep their defaults, so the bench uses the real device address, the status address and the bank range. It can therefore run bursts that cross the lower and upper bank edges.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  typedef struct packed {
    logic loadPtr;
    logic writeByte;
    logic clearStage;
    logic commitRegs;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_DEV,
    TX_ADDR,
    TX_DATA,
    TX_SKIP
  } txState_t;

  localparam logic [7:0] ST_CLEAR    = 8'h00;
  localparam logic [7:0] ST_SET_WEL  = 8'h02;
  localparam logic [7:0] ST_SET_BOTH = 8'h06;

endpackage

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
  import unlock_seq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter logic [7:0] DEV_ADDR = 8'hDE,
  parameter int COMMIT_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              abortEv,
  input  logic              byteEv,
  input  logic [DATA_W-1:0] byteVal,
  input  logic              statusSeen,
  input  logic [DATA_W-1:0] statusVal,
  input  logic              stageAny,
  output dpStrobe_t         strobe,
  output logic              wel,
  output logic              rwel,
  output logic              busy
);

  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES - 1);

  txState_t         st, stNxt;
  logic [CNT_W-1:0] cnt;
  logic             goodStop, doneNow, startCommit;

  assign doneNow     = busy && (cnt == '0);
  assign startCommit = goodStop && stageAny && wel && rwel && !busy;

  // Event decode; one event per cycle expected, abort wins over stop, stop over start
  always_comb begin
    stNxt    = st;
    strobe   = '0;
    goodStop = 1'b0;
    strobe.commitRegs = doneNow;
    if (abortEv) begin
      stNxt = TX_IDLE;
      strobe.clearStage = !busy;
    end else if (stopEv) begin
      goodStop = (st == TX_DATA);
      stNxt    = TX_IDLE;
    end else if (startEv) begin
      stNxt = TX_DEV;
      strobe.clearStage = !busy;
    end else if (byteEv) begin
      unique case (st)
        TX_DEV:  stNxt = (byteVal == DATA_W'(DEV_ADDR) && !busy) ? TX_ADDR : TX_SKIP;
        TX_ADDR: begin
          strobe.loadPtr = 1'b1;
          stNxt = TX_DATA;
        end
        TX_DATA: strobe.writeByte = 1'b1;
        default: stNxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= TX_IDLE;
    else       st <= stNxt;
  end

  // Enable latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else begin
      if (doneNow) rwel <= 1'b0;
      if (goodStop && statusSeen) begin
        if (statusVal == DATA_W'(ST_CLEAR)) begin
          wel  <= 1'b0;
          rwel <= 1'b0;
        end else if (statusVal == DATA_W'(ST_SET_WEL)) begin
          wel <= 1'b1;
        end else if (statusVal == DATA_W'(ST_SET_BOTH) && wel) begin
          wel  <= 1'b1;
          rwel <= 1'b1;
        end
      end
    end
  end

  // Commit timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (startCommit) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/unlock_seq_dp.sv
module unlock_seq_dp
  import unlock_seq_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter logic [7:0] BANK_BASE   = 8'h10,
  parameter logic [7:0] STATUS_ADDR = 8'h3F
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [DATA_W-1:0]          byteVal,
  output logic                       statusSeen,
  output logic [DATA_W-1:0]          statusVal,
  output logic                       stageAny,
  output logic [NUM_REGS*DATA_W-1:0] regFile
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [DATA_W-1:0] BASE_V   = DATA_W'(BANK_BASE);
  localparam logic [DATA_W-1:0] STATUS_V = DATA_W'(STATUS_ADDR);

  logic [DATA_W-1:0]   ptr, offset;
  logic                inBank, isStatus;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] vldVec;

  assign offset   = ptr - BASE_V;
  assign inBank   = (ptr >= BASE_V) && (offset < DATA_W'(NUM_REGS));
  assign idx      = offset[IDX_W-1:0];
  assign isStatus = (ptr == STATUS_V);
  assign stageAny = |vldVec;

  // Address pointer and pending status byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      statusSeen <= 1'b0;
      statusVal  <= '0;
    end else begin
      if (strobe.loadPtr)        ptr <= byteVal;
      else if (strobe.writeByte) ptr <= ptr + 1'b1;
      if (strobe.clearStage) begin
        statusSeen <= 1'b0;
      end else if (strobe.writeByte && isStatus) begin
        statusSeen <= 1'b1;
        statusVal  <= byteVal;
      end
    end
  end

  // One staging slot and one bank register per entry
  for (genvar g = 0; g < NUM_REGS; g++) begin : gEntry
    logic [DATA_W-1:0] stageR, regR;
    logic              vldR, hit;

    assign hit = inBank && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageR <= '0;
        regR   <= '0;
        vldR   <= 1'b0;
      end else begin
        if (strobe.commitRegs && vldR) regR <= stageR;
        if (strobe.clearStage || strobe.commitRegs) begin
          vldR <= 1'b0;
        end else if (strobe.writeByte && hit) begin
          vldR   <= 1'b1;
          stageR <= byteVal;
        end
      end
    end

    assign vldVec[g] = vldR;
    assign regFile[g*DATA_W +: DATA_W] = regR;
  end

endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
  import unlock_seq_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int DATA_W        = 8,
  parameter logic [7:0] DEV_ADDR    = 8'hDE,
  parameter logic [7:0] BANK_BASE   = 8'h10,
  parameter logic [7:0] STATUS_ADDR = 8'h3F,
  parameter int COMMIT_CYCLES = 500000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startEv,
  input  logic                       stopEv,
  input  logic                       abortEv,
  input  logic                       byteEv,
  input  logic [DATA_W-1:0]          byteVal,
  output logic                       wel,
  output logic                       rwel,
  output logic                       busy,
  output logic [NUM_REGS*DATA_W-1:0] regFile
);

  dpStrobe_t         strobe;
  logic              statusSeen, stageAny;
  logic [DATA_W-1:0] statusVal;

  unlock_seq_ctrl #(
    .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR), .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .abortEv(abortEv), .byteEv(byteEv), .byteVal(byteVal),
    .statusSeen(statusSeen), .statusVal(statusVal), .stageAny(stageAny),
    .strobe(strobe), .wel(wel), .rwel(rwel), .busy(busy)
  );

  unlock_seq_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
    .BANK_BASE(BANK_BASE), .STATUS_ADDR(STATUS_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteVal(byteVal),
    .statusSeen(statusSeen), .statusVal(statusVal), .stageAny(stageAny),
    .regFile(regFile)
  );

endmodule

// File: rtl/unlock_seq_chk.sv
module unlock_seq_chk #(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             stopEv,
  input logic             wel,
  input logic             rwel,
  input logic             busy,
  input logic [REG_W-1:0] regFile
);

  AST_RWEL_IMPLIES_WEL: assert property (@(posedge clk) disable iff (!rstN)
    rwel |-> wel); // R3

  AST_WEL_RISES_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(stopEv)); // R2

  AST_COMMIT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel && rwel)); // R5

  AST_BUSY_STARTS_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv)); // R5

  AST_RWEL_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !rwel); // R6

  AST_BANK_CHANGES_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busy) |-> $stable(regFile)); // R11

endmodule

bind unlock_seq unlock_seq_chk #(.REG_W(NUM_REGS*DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .stopEv(stopEv), .wel(wel), .rwel(rwel),
  .busy(busy), .regFile(regFile)
);

// File: tb/unlock_seq_tb.sv
module unlock_seq_tb;

  localparam int COMMIT = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startEv = 1'b0, stopEv = 1'b0, abortEv = 1'b0, byteEv = 1'b0;
  logic [7:0]  byteVal = 8'h00;
  logic        wel, rwel, busy;
  logic [63:0] regFile;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;

  unlock_seq #(.COMMIT_CYCLES(COMMIT)) u_dut (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .abortEv(abortEv), .byteEv(byteEv), .byteVal(byteVal),
    .wel(wel), .rwel(rwel), .busy(busy), .regFile(regFile)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modelFlat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  // One event per cycle, driven after a falling edge
  task automatic ev(input logic s, input logic p, input logic a, input logic b, input logic [7:0] v);
    startEv = s; stopEv = p; abortEv = a; byteEv = b; byteVal = v;
    @(negedge clk);
    startEv = 0; stopEv = 0; abortEv = 0; byteEv = 0; byteVal = 8'h00;
  endtask

  task automatic sStart();            ev(1, 0, 0, 0, 8'h00); endtask
  task automatic sStop();             ev(0, 1, 0, 0, 8'h00); endtask
  task automatic sAbort();            ev(0, 0, 1, 0, 8'h00); endtask
  task automatic sByte(input logic [7:0] v); ev(0, 0, 0, 1, v); endtask

  task automatic busWrite(input logic [7:0] dev, input logic [7:0] addr,
                          input int n, input logic [7:0] d [8]);
    sStart(); sByte(dev); sByte(addr);
    for (int i = 0; i < n; i++) sByte(d[i]);
    sStop();
  endtask

  task automatic statusWr(input logic [7:0] v);
    sStart(); sByte(8'hDE); sByte(8'h3F); sByte(v); sStop();
  endtask

  task automatic unlock();
    statusWr(8'h02); statusWr(8'h06);
  endtask

  task automatic tReset();
    chk("R1 wel", wel, 0); chk("R1 rwel", rwel, 0);
    chk("R1 busy", busy, 0); chk("R1 regFile", regFile, 0);
  endtask

  task automatic tLockedWrite();
    busWrite(8'hDE, 8'h10, 2, '{8'hAA, 8'hBB, 0, 0, 0, 0, 0, 0});
    chk("R7 busy", busy, 0);
    repeat (COMMIT + 2) @(negedge clk);
    chk("R7 regFile", regFile, modelFlat());
  endtask

  task automatic tStatusOrder();
    statusWr(8'h06);
    chk("R3 06h without wel: rwel", rwel, 0); chk("R3 06h without wel: wel", wel, 0);
    statusWr(8'h02);
    chk("R2 wel", wel, 1); chk("R2 rwel", rwel, 0); chk("R2 busy", busy, 0);
    statusWr(8'h04);
    chk("R3 other value: wel", wel, 1); chk("R3 other value: rwel", rwel, 0);
    statusWr(8'h06);
    chk("R3 06h with wel: rwel", rwel, 1); chk("R3 06h with wel: wel", wel, 1);
  endtask

  task automatic tForeign();
    busWrite(8'hDF, 8'h3F, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0});
    busWrite(8'hAE, 8'h3F, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0});
    busWrite(8'hAE, 8'h10, 1, '{8'h5A, 0, 0, 0, 0, 0, 0, 0});
    chk("R9 wel", wel, 1); chk("R9 rwel", rwel, 1); chk("R9 busy", busy, 0);
  endtask

  task automatic tBadEnd();
    sStart(); sByte(8'hDE); sByte(8'h10); sByte(8'hAA); sAbort();
    chk("R8 abort busy", busy, 0); chk("R8 abort rwel", rwel, 1);
    sStart(); sByte(8'hDE); sByte(8'h11); sByte(8'hBB);
    sStart(); sByte(8'hDF); sStop();
    chk("R8 restart busy", busy, 0); chk("R8 restart rwel", rwel, 1);
    chk("R8 wel", wel, 1);
    repeat (COMMIT + 2) @(negedge clk);
    chk("R8 regFile", regFile, modelFlat());
  endtask

  task automatic tCommitTail();
    // Burst from 15h runs past 17h; the fourth byte is dropped (R10)
    busWrite(8'hDE, 8'h15, 4, '{8'h55, 8'h66, 8'h77, 8'h88, 0, 0, 0, 0});
    model[5] = 8'h55; model[6] = 8'h66; model[7] = 8'h77;
    chk("R5 busy after stop", busy, 1);
    // Writes during busy are ignored (R11)
    busWrite(8'hDE, 8'h10, 1, '{8'hFF, 0, 0, 0, 0, 0, 0, 0});
    statusWr(8'h00);
    chk("R11 rwel during busy", rwel, 1); chk("R11 wel during busy", wel, 1);
    chk("R11 busy", busy, 1);
    chk("R11 regFile unchanged", regFile, 0);
    repeat (COMMIT + 2) @(negedge clk);
    chk("R5 busy done", busy, 0);
    chk("R10 R5 regFile", regFile, modelFlat());
    chk("R6 rwel cleared", rwel, 0); chk("R6 wel kept", wel, 1);
  endtask

  task automatic tNoRelock();
    busWrite(8'hDE, 8'h12, 1, '{8'h99, 0, 0, 0, 0, 0, 0, 0});
    chk("R6 no relock busy", busy, 0);
    repeat (COMMIT + 2) @(negedge clk);
    chk("R6 no relock regFile", regFile, modelFlat());
  endtask

  task automatic tClear();
    statusWr(8'h02); statusWr(8'h06);
    statusWr(8'h00);
    chk("R4 wel", wel, 0); chk("R4 rwel", rwel, 0);
  endtask

  task automatic tExactWindow();
    unlock();
    busWrite(8'hDE, 8'h10, 8, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08});
    for (int i = 0; i < 8; i++) model[i] = 8'(i + 1);
    repeat (COMMIT - 1) @(negedge clk);
    chk("R5 busy at last cycle", busy, 1);
    chk("R5 not yet written", regFile[7:0], 8'h00);
    @(negedge clk);
    chk("R5 busy fell", busy, 0);
    chk("R5 full burst", regFile, modelFlat());
  endtask

  task automatic tLowEdge();
    unlock();
    busWrite(8'hDE, 8'h0E, 4, '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 0, 0, 0, 0});
    model[0] = 8'hE2; model[1] = 8'hE3;
    repeat (COMMIT + 2) @(negedge clk);
    chk("R10 low edge", regFile, modelFlat());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLockedWrite();
    tStatusOrder();
    tForeign();
    tBadEnd();
    tCommitTail();
    tNoRelock();
    tClear();
    tExactWindow();
    tLowEdge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule